// File: doc/BRIEF.md
# Synchronous master serial receiver

This block receives words over a clocked serial link on which it is the clock master. A programmable divider sets the shift clock, which the block drives out on `sclk_o` while a reception is active and holds low otherwise. The single data line `sdata_i` is sampled on each falling edge of that clock, least-significant bit first. Words are 8 bits long, or 9 bits in wide mode. Each finished word moves from the shift register into a two-entry receive queue.

Software controls the block through a small register port with three registers: control/status, data and divider. There are two ways to start reception. A one-shot enable takes a single word and then clears itself. A streaming enable keeps receiving until it is cleared, and it wins when both enables are set. A ready flag shows that the queue holds data, and it drives an interrupt when the interrupt enable is set. If a word completes while the queue is full, an overrun flag is raised. While that flag is set, no further words are loaded into the queue. Writing the control register with the streaming enable clear removes the flag.

Top module: `clkser_rx`

## Requirements
- R1: After reset, every control bit is 0, the divider is 0, the queue is empty, the ready and overrun flags are 0, `sclk_o` is low and `irq_o` is low.
- R2: Divider register (address 2) holds N. While reception runs, `sclk_o` toggles every N+1 clock cycles, so a full shift-clock period is 2(N+1) cycles. The first edge is a rise. `sclk_o` is low whenever reception is not running.
- R3: `sdata_i` is sampled on each falling edge of `sclk_o`, least-significant bit first. A word is 8 falls long, or 9 falls when the wide bit (control bit 2) is set. In 8-bit mode the stored ninth bit is 0.
- R4: Control bit 0 is the one-shot enable and bit 4 is the port enable. With the port enabled, the one-shot enable set and the streaming enable clear, exactly one word is received. The one-shot bit then clears itself and the clock stops.
- R5: Control bit 1 is the streaming enable. While it is set, words are received back to back until it is cleared. If both enables are set, streaming behaviour applies: reception continues past the first word and the one-shot bit is not cleared.
- R6: The receive queue holds two words. A third word can be shifting in while both entries are full.
- R7: If a word completes while the queue is full, the overrun flag (control read bit 6) is set and that word is discarded.
- R8: While the overrun flag is set, no word is loaded into the queue, even when the queue has room. The flag is cleared only by a control write whose bit 1 is 0.
- R9: The ready flag (control read bit 5) is read-only. It is 1 exactly while the queue is not empty. `irq_o` is 1 exactly when the ready flag and the interrupt enable (control bit 3) are both 1.
- R10: Reading the data register (address 1) returns the low 8 bits of the oldest entry and removes it. Control read bit 7 shows the ninth bit of the oldest entry, so after a data read it shows the ninth bit of the next entry.
- R11: Clearing the port enable, or clearing both enables, during a word aborts that word. The clock returns low, the queue is left unchanged, and the next reception starts from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 2 divider |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe; a data read removes the oldest entry |
| rd_addr | input | 2 | Read address: 0 control/status, 1 data, 2 divider |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| sclk_o | output | 1 | Generated shift clock |
| sdata_i | input | 1 | Serial data line |
| irq_o | output | 1 | Receive interrupt |

## Verification
The bench acts as a slave and feeds bits on each rise of the generated clock. A scoreboard queue holds the words the reads must return. The first corner case fills the queue and then shifts a third and a fourth word. A design that overwrote an entry, or that loaded the fourth word once room appeared while overrun was still set, would return the wrong data or raise ready again. The second case sets both enables at once. It exposes a design that lets the one-shot bit win and stops after one word. The third case aborts a word after three bits and then receives a new word. A shifter that kept its bit count would return a corrupted value. The bench also checks the ninth-bit status of a two-word queue before and after a pop, which catches a status field that is not taken from the oldest entry.

// File: rtl/clkser_pkg.sv
package clkser_pkg;
  localparam int unsigned WORD_MAX = 9;
  localparam int unsigned BIT_W    = 4;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_DIV  = 2'd2;

  typedef logic [WORD_MAX-1:0] word_t;

  typedef struct packed {
    logic port_on;
    logic ie;
    logic wide;
    logic stream;
    logic one_shot;
  } ctrl_t;

  // number of shift-clock falls that make up one word
  function automatic logic [BIT_W-1:0] word_bits(input logic wide);
    return wide ? BIT_W'(9) : BIT_W'(8);
  endfunction

  // system clocks per shift-clock half period
  function automatic int unsigned half_cycles(input logic [7:0] div);
    return int'(div) + 1;
  endfunction

  function automatic word_t put_bit(input word_t w, input logic [BIT_W-1:0] idx,
                                    input logic b);
    word_t r;
    r = w;
    r[idx] = b;
    return r;
  endfunction
endpackage

// File: rtl/clkser_baud.sv
module clkser_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic             edge_now;

  assign edge_now = run && (cnt == div);
  assign fall_evt = edge_now && sclk;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (edge_now) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/clkser_shifter.sv
module clkser_shifter
  import clkser_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  fall_evt,
  input  logic  sdata,
  input  logic  wide,
  output logic  done_evt,
  output word_t word_o
);
  logic [BIT_W-1:0] bitcnt;
  logic [BIT_W-1:0] last_idx;
  word_t            shreg;

  assign last_idx = word_bits(wide) - BIT_W'(1);
  assign done_evt = run && fall_evt && (bitcnt == last_idx);
  assign word_o   = put_bit(shreg, bitcnt, sdata);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      bitcnt <= '0;
      shreg  <= '0;
    end else if (fall_evt) begin
      if (bitcnt == last_idx) begin
        bitcnt <= '0;
        shreg  <= '0;
      end else begin
        bitcnt <= bitcnt + BIT_W'(1);
        shreg  <= word_o;
      end
    end
  end
endmodule

// File: rtl/clkser_fifo.sv
module clkser_fifo #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [WIDTH-1:0]             din,
  input  logic                         pop,
  output logic [WIDTH-1:0]             head,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   cnt
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push && !full) begin
        mem[wp] <= din;
        wp      <= nxt(wp);
      end
      if (pop && !empty) rp <= nxt(rp);
      case ({push && !full, pop && !empty})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/clkser_rx.sv
module clkser_rx
  import clkser_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       sclk_o,
  input  logic       sdata_i,
  output logic       irq_o
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  ctrl_t            ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic             ovr_q;

  // named internal events
  logic    run, ctrl_wr, div_wr, fall_evt, done_evt, push_evt, ovr_evt, pop_evt;
  logic    one_shot_q, stream_q;
  logic    fifo_full, fifo_empty;
  logic [CW-1:0] fifo_cnt;
  word_t   rx_word, head_word;

  assign one_shot_q = ctrl_q.one_shot;
  assign stream_q   = ctrl_q.stream;
  assign run      = ctrl_q.port_on && (ctrl_q.one_shot || ctrl_q.stream);
  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  assign div_wr   = wr_en && (wr_addr == A_DIV);
  assign push_evt = done_evt && !ovr_q && !fifo_full;
  assign ovr_evt  = done_evt && !ovr_q && fifo_full;
  assign pop_evt  = rd_en && (rd_addr == A_DATA) && !fifo_empty;

  clkser_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q),
    .sclk(sclk_o), .fall_evt(fall_evt)
  );

  clkser_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .run(run), .fall_evt(fall_evt),
    .sdata(sdata_i), .wide(ctrl_q.wide), .done_evt(done_evt), .word_o(rx_word)
  );

  clkser_fifo #(.WIDTH(WORD_MAX), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .din(rx_word), .pop(pop_evt),
    .head(head_word), .full(fifo_full), .empty(fifo_empty), .cnt(fifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q <= ctrl_t'(wr_data[4:0]);
      end else if (done_evt && !ctrl_q.stream) begin
        ctrl_q.one_shot <= 1'b0;
      end
      if (div_wr) div_q <= wr_data[DIV_W-1:0];
      if (ctrl_wr && !wr_data[1]) ovr_q <= 1'b0;
      else if (ovr_evt)           ovr_q <= 1'b1;
    end
  end

  assign irq_o = ctrl_q.ie && !fifo_empty;

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {head_word[8] && !fifo_empty, ovr_q, !fifo_empty, ctrl_q};
      A_DATA:  rd_data = fifo_empty ? 8'h00 : head_word[7:0];
      A_DIV:   rd_data = 8'(div_q);
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/clkser_rx_chk.sv
module clkser_rx_chk #(
  parameter int unsigned DEPTH = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       run,
  input logic                       sclk_o,
  input logic                       fall_evt,
  input logic                       done_evt,
  input logic                       push_evt,
  input logic                       ovr_q,
  input logic                       fifo_full,
  input logic                       fifo_empty,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  input logic                       stream_q,
  input logic                       one_shot_q,
  input logic                       ctrl_wr,
  input logic                       irq_o
);
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk_o);

  p_fall_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |-> (sclk_o ##1 !sclk_o));

  p_one_shot_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !stream_q && !ctrl_wr) |=> !one_shot_q);

  p_stream_continues_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && stream_q && !ctrl_wr) |=> run);

  p_depth_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= DEPTH);

  p_overrun_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && fifo_full && !ctrl_wr) |=> ovr_q);

  p_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> !push_evt);

  p_push_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> !fifo_empty);

  p_irq_needs_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !fifo_empty);
endmodule

bind clkser_rx clkser_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .sclk_o(sclk_o), .fall_evt(fall_evt),
  .done_evt(done_evt), .push_evt(push_evt), .ovr_q(ovr_q), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .fifo_cnt(fifo_cnt), .stream_q(stream_q),
  .one_shot_q(one_shot_q), .ctrl_wr(ctrl_wr), .irq_o(irq_o)
);

// File: tb/clkser_rx_tb_top.sv
`timescale 1ns/1ps
module clkser_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       sclk_o, irq_o;
  logic       sdata = 1'b0;

  int checks = 0, failures = 0;
  bit finished = 0;
  bit bq[$];            // slave bit stream, LSB first
  logic [8:0] exp_q[$]; // scoreboard of expected words
  realtime last_rise = 0, prev_rise = 0;

  always #2.5 clk = ~clk;

  clkser_rx dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .sclk_o(sclk_o),
    .sdata_i(sdata), .irq_o(irq_o)
  );

  // slave model: present the next bit after each rising shift-clock edge
  always @(posedge sclk_o) begin
    prev_rise = last_rise;
    last_rise = $realtime;
    #1;
    sdata = (bq.size() != 0) ? bq.pop_front() : 1'b0;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // driver: queue the bits, and the word itself when it must come back
  task automatic send_word(input logic [8:0] w, input bit wide, input bit keep);
    int n = wide ? 9 : 8;
    for (int i = 0; i < n; i++) bq.push_back(w[i]);
    if (keep) exp_q.push_back(wide ? w : {1'b0, w[7:0]});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor side: pop the data register and compare with the scoreboard
  task automatic pop_check(input string tag);
    logic [7:0] d;
    logic [8:0] e;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 9'h1FF;
    rd(2'd1, d);
    check(tag, {24'd0, d}, {24'd0, e[7:0]});
  endtask

  task automatic ctrl_check(input string tag, input logic [7:0] e);
    logic [7:0] d;
    rd(2'd0, d);
    check(tag, {24'd0, d}, {24'd0, e});
  endtask

  task automatic wait_falls(input int n);
    repeat (n) @(negedge sclk_o);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    ctrl_check("R1 ctrl after reset", 8'h00);
    rd(2'd2, d); check("R1 divider after reset", {24'd0, d}, 32'd0);
    check("R1 sclk idle", {31'd0, sclk_o}, 32'd0);
    check("R1 irq idle", {31'd0, irq_o}, 32'd0);

    // R2 R3 R4 single 8-bit word, divider 3
    wr(2'd2, 8'd3);
    send_word(9'h0A5, 1'b0, 1'b1);
    wr(2'd0, 8'h11);
    wait_falls(8);
    ctrl_check("R4 one-shot cleared, R9 ready set", 8'h30);
    check("R2 period for N=3", 32'(int'((last_rise - prev_rise) * 1000)), 32'd40000);
    repeat (20) @(posedge clk);
    #1 check("R2 clock idles low after word", {31'd0, sclk_o}, 32'd0);
    check("R9 irq off while disabled", {31'd0, irq_o}, 32'd0);
    wr(2'd0, 8'h18);
    #1 check("R9 irq with enable and data", {31'd0, irq_o}, 32'd1);
    pop_check("R3 data LSB first 8-bit");
    ctrl_check("R9 ready cleared after last read", 8'h18);
    #1 check("R9 irq cleared when empty", {31'd0, irq_o}, 32'd0);

    // R10 9-bit words, divider 0
    wr(2'd2, 8'd0);
    send_word(9'h13C, 1'b1, 1'b1);
    wr(2'd0, 8'h15);
    wait_falls(9);
    check("R2 period for N=0", 32'(int'((last_rise - prev_rise) * 1000)), 32'd10000);
    send_word(9'h0C3, 1'b1, 1'b1);
    wr(2'd0, 8'h15);
    wait_falls(9);
    ctrl_check("R10 ninth bit of head is 1", 8'hB4);
    pop_check("R10 first wide word");
    ctrl_check("R10 ninth bit follows next entry", 8'h34);
    pop_check("R10 second wide word");
    ctrl_check("R10 queue empty", 8'h14);

    // R6 R7 R8 overrun in streaming mode, divider 3
    wr(2'd2, 8'd3);
    send_word(9'h011, 1'b0, 1'b1);
    send_word(9'h022, 1'b0, 1'b1);
    send_word(9'h033, 1'b0, 1'b0);
    wr(2'd0, 8'h12);
    wait_falls(24);
    ctrl_check("R7 overrun set, R6 two held", 8'h72);
    pop_check("R6 first held word");
    pop_check("R7 second held word, third discarded");
    ctrl_check("R9 empty with overrun", 8'h52);
    wait_falls(8);
    ctrl_check("R8 no load while overrun", 8'h52);
    wr(2'd0, 8'h10);
    ctrl_check("R8 overrun cleared by stream clear", 8'h10);

    // R5 both enables: streaming wins
    bq.delete();
    send_word(9'h05A, 1'b0, 1'b1);
    send_word(9'h06B, 1'b0, 1'b1);
    wr(2'd0, 8'h13);
    wait_falls(16);
    ctrl_check("R5 one-shot kept, reception continued", 8'h33);
    wr(2'd0, 8'h10);
    pop_check("R5 first streamed word");
    pop_check("R5 second streamed word");

    // R11 abort mid-word
    bq.delete();
    send_word(9'h0FF, 1'b0, 1'b0);
    wr(2'd0, 8'h11);
    repeat (3) @(negedge sclk_o);
    wr(2'd0, 8'h01);
    repeat (2) @(posedge clk);
    #1 check("R11 clock low after abort", {31'd0, sclk_o}, 32'd0);
    ctrl_check("R11 queue unchanged by abort", 8'h01);
    bq.delete();
    send_word(9'h096, 1'b0, 1'b1);
    wr(2'd0, 8'h11);
    wait_falls(8);
    pop_check("R11 next word starts at bit 0");
    ctrl_check("R11 one-shot done, empty", 8'h10);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule